// File: doc/BRIEF.md
# Phase Token Ring with Phase-Count Discovery

This block spreads the switching phase of a multiphase converter over a chain of stages. All stages run from one fast clock whose rate is the number of phases times the switching rate. A single token travels around a ring: the controller end drives the first stage, each stage hands the token to the next one clock later, and the last stage returns it to the controller. A stage owns its phase in the clock period in which it holds the token. Its turn strobe is high for that whole period, and the falling clock edge in the middle of that period starts the stage's PWM cycle.

After reset the controller launches one token and counts clocks until the token comes back. The count is the number of phases in the ring and is kept until the next reset. From then on the controller forwards each returning token straight back into the ring, so the phases fire in order with a period equal to the count. A token that does not come back in time, or that comes back at the wrong moment, marks the ring as faulty. Stages can be built as two-phase pairs, where the second phase of a pair takes its token from the first phase internally. A stage can also be isolated for debug: it keeps passing the token but never takes a turn.

Top module: `phase_ring`

## Requirements
- R1: While reset is low, every stage token output, every turn strobe, `ctl_tok_out`, `ring_ready`, `ring_fault` and `phase_count` are 0. After reset, each stage token output equals that stage's effective token input delayed by exactly one clock.
- R2: A stage's turn strobe is 1 exactly in the clock periods in which its token output is 1, provided its isolate input is 0.
- R3: A stage whose isolate input is 1 keeps its turn strobe at 0, and its token still passes to the next stage with the normal one-clock delay.
- R4: With `PAIRED` = 1, stage 2k+1 takes its token from the output of stage 2k, and its `stg_tok_in` bit has no effect.
- R5: In the second clock period after reset is released, `ctl_tok_out` is 1 for exactly one period (the launch). It is not raised again before the token returns.
- R6: If `ctl_tok_in` is 1 in the k-th period after the launch period (1 <= k <= `MAX_WAIT`), then `phase_count` becomes k and `ring_ready` becomes 1 from the next period, with `ring_fault` 0. A series ring of n stages gives k = n.
- R7: If no token returns in the `MAX_WAIT` periods after the launch, `ring_fault` becomes 1 in the following period, and `phase_count` and `ring_ready` stay 0.
- R8: While `ring_ready` is 1, a token arriving on `ctl_tok_in` on schedule is driven on `ctl_tok_out` in the same period. Each stage then holds the token once every `phase_count` periods.
- R9: While `ring_ready` is 1, a token arriving at any other distance than `phase_count` periods after the previous one, or no token when one is due, sets `ring_fault` and clears `ring_ready` from the next period. The bad token is not forwarded, and later tokens are not forwarded either.
- R10: `ring_fault` and `phase_count` hold their values until reset. A new reset clears them and starts a fresh discovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_tok_in | input | NUM_STAGES | Token input of each stage |
| stg_isolate | input | NUM_STAGES | Debug isolation of each stage (1 = isolated) |
| stg_tok_out | output | NUM_STAGES | Registered token output of each stage |
| stg_turn | output | NUM_STAGES | Per-stage turn strobe |
| ctl_tok_in | input | 1 | Token returning from the last stage |
| ctl_tok_out | output | 1 | Token launched or forwarded into the first stage |
| phase_count | output | $clog2(MAX_WAIT+1) | Discovered number of phases, 0 until found or after a timeout |
| ring_ready | output | 1 | Discovery succeeded and the ring is circulating |
| ring_fault | output | 1 | Ring timed out or lost its schedule |

## Verification
If the controller's cycle counter starts or stops one period off, the reported phase count is off by one right when `ring_ready` rises, and every later return is then judged off-schedule within one ring period. A stage register that drops or duplicates the token shows up within the same period on that stage's output and turn strobe, and again in `ring_fault` once the token is due back. If the pair wiring or the forward path is wrong, the ring either never comes ready or its turn pattern loses the `phase_count` spacing within one or two ring periods. The directed scenarios therefore look at every clock period from release to two dozen periods later, and compare the exact periods in which tokens, strobes, readiness and faults appear.

// File: rtl/phase_ring_pkg.sv
package phase_ring_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_LAUNCH = 3'd1,
      S_DISC   = 3'd2,
      S_RUN    = 3'd3,
      S_FAULT  = 3'd4
   } ring_state_e;

   function automatic int cnt_width(input int max_wait);
      return (max_wait < 2) ? 1 : $clog2(max_wait + 1);
   endfunction

endpackage

// File: rtl/phase_slot.sv
module phase_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_in,
   input  logic isolate,
   output logic tok_out,
   output logic turn
);

   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= tok_in;
   end

   assign tok_out = held_q;
   assign turn    = held_q & ~isolate;

   // R2: a turn is only taken for a token that was present one clock ago
   assert_turn_follows_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
      turn |-> $past(tok_in));

endmodule

// File: rtl/phase_pair.sv
module phase_pair (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_in,
   input  logic [1:0] isolate,
   output logic [1:0] tok_out,
   output logic [1:0] turn
);

   logic link;

   phase_slot u_first (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_in  (tok_in),
      .isolate (isolate[0]),
      .tok_out (link),
      .turn    (turn[0])
   );

   phase_slot u_second (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_in  (link),
      .isolate (isolate[1]),
      .tok_out (tok_out[1]),
      .turn    (turn[1])
   );

   assign tok_out[0] = link;

   // R4: second phase of a package follows the first by one clock
   assert_pair_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out[1] == $past(tok_out[0]));

endmodule

// File: rtl/ring_ctl.sv
module ring_ctl
   import phase_ring_pkg::*;
#(
   parameter int MAX_WAIT = 16,
   parameter int CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_in,
   output logic             tok_out,
   output logic [CNT_W-1:0] phase_count,
   output logic             ring_ready,
   output logic             ring_fault
);

   localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(MAX_WAIT);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   ring_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] count_q;
   logic             on_time;
   logic             relay;

   assign on_time = (state == S_RUN) && (cnt == count_q);
   assign relay   = tok_in && ((state == S_DISC) || on_time);
   assign tok_out = (state == S_LAUNCH) || relay;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         count_q <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               state <= S_LAUNCH;
               cnt   <= '0;
            end
            S_LAUNCH: begin
               state <= S_DISC;
               cnt   <= ONE;
            end
            S_DISC: begin
               if (tok_in) begin
                  count_q <= cnt;
                  cnt     <= ONE;
                  state   <= S_RUN;
               end else if (cnt == WAIT_LIM) begin
                  count_q <= '0;
                  state   <= S_FAULT;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            S_RUN: begin
               if (tok_in) begin
                  if (on_time) cnt   <= ONE;
                  else         state <= S_FAULT;
               end else if (cnt == count_q) begin
                  state <= S_FAULT;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            S_FAULT: state <= S_FAULT;
            default: state <= S_FAULT;
         endcase
      end
   end

   assign phase_count = count_q;
   assign ring_ready  = (state == S_RUN);
   assign ring_fault  = (state == S_FAULT);

   // R5: the launch period is always followed by listening
   assert_launch_then_listen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LAUNCH) |=> (state == S_DISC) && !ring_ready);

   // R6: a circulating ring always reports a count inside the window
   assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ring_ready |-> (phase_count != '0) && (phase_count <= WAIT_LIM));

   // R7: discovery never waits past its limit
   assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DISC) |-> (cnt <= WAIT_LIM));

   // R9: a faulted ring forwards nothing
   assert_no_relay_faulted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ring_fault |-> !tok_out);

   // R10: fault is sticky
   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ring_fault |=> ring_fault);

   // R10: count frozen once discovery has ended
   assert_count_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_ready || ring_fault) |=> $stable(phase_count));

endmodule

// File: rtl/phase_ring.sv
module phase_ring
   import phase_ring_pkg::*;
#(
   parameter int NUM_STAGES = 4,
   parameter int MAX_WAIT   = 16,
   parameter bit PAIRED     = 1'b1,
   localparam int CNT_W     = cnt_width(MAX_WAIT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STAGES-1:0] stg_tok_in,
   input  logic [NUM_STAGES-1:0] stg_isolate,
   output logic [NUM_STAGES-1:0] stg_tok_out,
   output logic [NUM_STAGES-1:0] stg_turn,
   input  logic                  ctl_tok_in,
   output logic                  ctl_tok_out,
   output logic [CNT_W-1:0]      phase_count,
   output logic                  ring_ready,
   output logic                  ring_fault
);

   if (NUM_STAGES < 1) begin : g_bad_count
      $error("phase_ring: NUM_STAGES must be at least 1");
   end
   if (PAIRED && (NUM_STAGES % 2 != 0)) begin : g_bad_pairs
      $error("phase_ring: paired build needs an even NUM_STAGES");
   end
   if (MAX_WAIT < NUM_STAGES) begin : g_bad_wait
      $error("phase_ring: MAX_WAIT must cover NUM_STAGES");
   end

   if (PAIRED) begin : g_pairs
      localparam int NPAIR = NUM_STAGES / 2;
      logic [NPAIR-1:0] second_in_unused;
      for (genvar k = 0; k < NPAIR; k++) begin : g_pair
         phase_pair u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .tok_in  (stg_tok_in[2*k]),
            .isolate (stg_isolate[2*k+1 -: 2]),
            .tok_out (stg_tok_out[2*k+1 -: 2]),
            .turn    (stg_turn[2*k+1 -: 2])
         );
         assign second_in_unused[k] = stg_tok_in[2*k+1];
      end
   end else begin : g_singles
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_slot
         phase_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .tok_in  (stg_tok_in[i]),
            .isolate (stg_isolate[i]),
            .tok_out (stg_tok_out[i]),
            .turn    (stg_turn[i])
         );
      end
   end

   ring_ctl #(
      .MAX_WAIT (MAX_WAIT),
      .CNT_W    (CNT_W)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .tok_in      (ctl_tok_in),
      .tok_out     (ctl_tok_out),
      .phase_count (phase_count),
      .ring_ready  (ring_ready),
      .ring_fault  (ring_fault)
   );

   // R3: isolated stages never take a turn
   assert_isolated_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stg_turn & stg_isolate) == 0);

   // R8: the controller's token goes out only at launch or alongside a returning token
   assert_forward_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_tok_out && ring_ready) |-> ctl_tok_in);

endmodule

// File: tb/phase_ring_bench.sv
`timescale 1ns/1ps
module phase_ring_bench;

   localparam int N   = 4;
   localparam int MW  = 16;
   localparam int CW  = 5;
   localparam int WIN = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  stg_in;
   logic [N-1:0]  stg_iso = '0;
   logic [N-1:0]  stg_out;
   logic [N-1:0]  stg_turn;
   logic          ctl_in;
   logic          ctl_out;
   logic [CW-1:0] phase_count;
   logic          ring_ready;
   logic          ring_fault;

   int   topo  = 0;
   logic junk1 = 1'b0;
   logic inj   = 1'b0;
   logic cut   = 1'b0;
   logic ret;

   int checks = 0;
   int errors = 0;

   logic [N-1:0]  h_out  [0:WIN];
   logic [N-1:0]  h_in   [0:WIN];
   logic [N-1:0]  h_turn [0:WIN];
   logic          h_ctl  [0:WIN];
   logic          h_rdy  [0:WIN];
   logic          h_flt  [0:WIN];
   logic [CW-1:0] h_cnt  [0:WIN];

   always #4 clk = ~clk;

   phase_ring #(.NUM_STAGES(N), .MAX_WAIT(MW), .PAIRED(1'b1)) u_phase_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .stg_tok_in  (stg_in),
      .stg_isolate (stg_iso),
      .stg_tok_out (stg_out),
      .stg_turn    (stg_turn),
      .ctl_tok_in  (ctl_in),
      .ctl_tok_out (ctl_out),
      .phase_count (phase_count),
      .ring_ready  (ring_ready),
      .ring_fault  (ring_fault)
   );

   always_comb begin
      stg_in[0] = ctl_out;
      stg_in[1] = junk1;
      stg_in[2] = stg_out[1];
      stg_in[3] = stg_out[2];
      case (topo)
         0:       ret = stg_out[3];
         1:       ret = stg_out[1];
         3:       ret = stg_out[0];
         default: ret = 1'b0;
      endcase
      ctl_in = (ret & ~cut) | inj;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit check_idle);
      rst_n = 1'b0;
      inj = 1'b0;
      cut = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      if (check_idle) begin
         chk(stg_out == '0 && stg_turn == '0 && !ctl_out, "R1 reset tokens",
             int'({stg_out, stg_turn, ctl_out}), 0);
         chk(!ring_ready && !ring_fault && phase_count == '0, "R1 reset status",
             int'({ring_ready, ring_fault, phase_count}), 0);
      end
      rst_n = 1'b1;
   endtask

   // release happens at the negedge labelled 0; index j samples after the j-th posedge
   task automatic capture(input int cut_at, input int inj_at);
      for (int idx = 1; idx <= WIN; idx++) begin
         @(negedge clk);
         inj = (idx == inj_at);
         cut = (cut_at >= 0) && (idx >= cut_at);
         #1;
         h_out[idx]  = stg_out;
         h_in[idx]   = {stg_in[3], stg_in[2], stg_out[0], stg_in[0]};
         h_turn[idx] = stg_turn;
         h_ctl[idx]  = ctl_out;
         h_rdy[idx]  = ring_ready;
         h_flt[idx]  = ring_fault;
         h_cnt[idx]  = phase_count;
      end
      inj = 1'b0;
   endtask

   function automatic int first_ready();
      for (int i = 1; i <= WIN; i++) if (h_rdy[i]) return i;
      return -1;
   endfunction

   function automatic int first_fault();
      for (int i = 1; i <= WIN; i++) if (h_flt[i]) return i;
      return -1;
   endfunction

   function automatic int turn_mismatch(input int st, input int period);
      int bad = 0;
      for (int i = 1; i <= WIN; i++) begin
         bit exp = (i >= 2 + st) && (((i - 2 - st) % period) == 0);
         if (h_turn[i][st] != exp) bad++;
      end
      return bad;
   endfunction

   task automatic test_full_ring();
      int bad = 0;
      int launches = 0;
      topo = 0; junk1 = 1'b1; stg_iso = '0;
      do_reset(1'b1);
      capture(-1, -1);
      chk(h_ctl[1] == 1'b1, "R5 launch period", int'(h_ctl[1]), 1);
      for (int i = 1; i <= 4; i++) if (h_ctl[i]) launches++;
      chk(launches == 1, "R5 single launch", launches, 1);
      chk(first_ready() == 6, "R6 ready period", first_ready(), 6);
      chk(h_cnt[6] == 5'd4 && !h_flt[6], "R6 count four", int'(h_cnt[6]), 4);
      for (int i = 2; i <= WIN; i++) if (h_out[i] != h_in[i-1]) bad++;
      chk(bad == 0, "R1 one-clock shift", bad, 0);
      for (int s = 0; s < N; s++) chk(turn_mismatch(s, 4) == 0, "R2 turn pattern", turn_mismatch(s, 4), 0);
      chk(h_out[3][1] && !h_out[4][1] && h_out[7][1], "R4 pin ignored", int'(h_out[4][1]), 0);
      chk(h_ctl[5] && h_ctl[9] && h_ctl[13] && !h_ctl[6], "R8 forward", int'({h_ctl[5], h_ctl[9], h_ctl[13]}), 7);
      chk(!h_flt[WIN] && h_rdy[WIN], "R8 steady run", int'(h_flt[WIN]), 0);
      junk1 = 1'b0;
   endtask

   task automatic test_one_pair();
      topo = 1; stg_iso = '0;
      do_reset(1'b0);
      capture(-1, -1);
      chk(first_ready() == 4 && h_cnt[4] == 5'd2, "R6 count two", int'(h_cnt[4]), 2);
      chk(turn_mismatch(0, 2) == 0 && turn_mismatch(1, 2) == 0, "R8 period two",
          turn_mismatch(0, 2) + turn_mismatch(1, 2), 0);
   endtask

   task automatic test_single();
      topo = 3; stg_iso = '0;
      do_reset(1'b0);
      capture(-1, -1);
      chk(first_ready() == 3 && h_cnt[3] == 5'd1, "R6 count one", int'(h_cnt[3]), 1);
      chk(turn_mismatch(0, 1) == 0 && !h_flt[WIN], "R8 period one", turn_mismatch(0, 1), 0);
   endtask

   task automatic test_isolate();
      int on2 = 0;
      topo = 0; stg_iso = 4'b0100;
      do_reset(1'b0);
      capture(-1, -1);
      for (int i = 1; i <= WIN; i++) if (h_turn[i][2]) on2++;
      chk(on2 == 0, "R3 isolated strobe", on2, 0);
      chk(h_out[4][2] && h_out[8][2] && !h_out[5][2], "R3 token passes", int'(h_out[4][2]), 1);
      chk(h_cnt[6] == 5'd4 && turn_mismatch(3, 4) == 0, "R3 ring intact", int'(h_cnt[6]), 4);
      stg_iso = '0;
   endtask

   task automatic test_timeout();
      topo = 2; stg_iso = '0;
      do_reset(1'b0);
      capture(-1, -1);
      chk(first_fault() == MW + 2, "R7 timeout period", first_fault(), MW + 2);
      chk(h_cnt[WIN] == '0 && !h_rdy[WIN], "R7 count zero", int'(h_cnt[WIN]), 0);
   endtask

   task automatic test_early();
      topo = 0; stg_iso = '0;
      do_reset(1'b0);
      capture(-1, 7);
      chk(!h_ctl[7], "R9 early not forwarded", int'(h_ctl[7]), 0);
      chk(!h_flt[7] && h_flt[8] && !h_rdy[8], "R9 early fault", int'({h_flt[7], h_flt[8]}), 1);
      chk(!h_turn[10][0] && !h_ctl[9], "R9 ring stopped", int'(h_turn[10][0]), 0);
      chk(h_flt[WIN] && h_cnt[WIN] == 5'd4, "R10 hold", int'(h_cnt[WIN]), 4);
   endtask

   task automatic test_lost();
      topo = 0; stg_iso = '0;
      do_reset(1'b0);
      capture(6, -1);
      chk(!h_flt[9] && h_flt[10], "R9 missing token", int'({h_flt[9], h_flt[10]}), 1);
      chk(h_cnt[WIN] == 5'd4 && !h_rdy[WIN], "R10 count kept", int'(h_cnt[WIN]), 4);
   endtask

   task automatic test_restart();
      topo = 0; stg_iso = '0;
      repeat (30) @(negedge clk);
      #1;
      chk(ring_fault == 1'b1, "R10 fault sticky", int'(ring_fault), 1);
      do_reset(1'b1);
      capture(-1, -1);
      chk(first_ready() == 6 && h_cnt[6] == 5'd4 && !h_flt[WIN], "R10 rediscovery", int'(h_cnt[6]), 4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 20000 expected fewer cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      test_full_ring();
      test_one_pair();
      test_single();
      test_isolate();
      test_timeout();
      test_early();
      test_lost();
      test_restart();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule